// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Source Select

This block sits at the leaf of a clock tree and produces one clock-enable strobe for one peripheral. Up to sixteen source strobes arrive, each a single-cycle pulse in the local clock domain that marks one edge of some slower clock. A control word picks one of them and gates the output. A divide word holds a divisor with an integer part and a fraction part. The block turns the chosen pulse train into a slower train whose average rate is the source rate times 2^FRAC_BITS divided by that divisor.

Source slot 0 never produces a pulse. Slot 1 is meant for the crystal reference and slots 2 and 3 for two test clocks. The remaining slots are wired to whatever each instance needs. The divisor field has its integer part anchored at bit 12 of the divide word, and its width on each side of that boundary is set per instance. An instance built with no integer or fraction bits skips the divider entirely and forwards the chosen strobe as it is. The fraction is handled by a first-order accumulator: it adds 2^FRAC_BITS for every selected pulse, and when the sum reaches the divisor it emits a pulse and subtracts the divisor. Any write to the control or divide word clears the accumulator, so a new ratio always starts from a clean phase.

Top module: `clkdiv_mux`

## Requirements
- R1: Source slot 0 is a dead input. While slot 0 is selected, tick_o stays low whatever src_tick_i carries.
- R2: While the enable bit (control bit 4) is clear, tick_o stays low.
- R3: ctl_rdata_o bit 7 (busy) always equals the stored enable bit 4. Bits [3:0] return the stored source index and bits 6:5 read zero. The written value of bit 7 is ignored.
- R4: The divisor is the concatenation {DIV[12+INT_BITS-1:12], DIV[11:12-FRAC_BITS]}. All other bits of the divide word have no effect.
- R5: With a divisor D greater than 2^FRAC_BITS, N selected strobes after a clean start give floor(N*2^FRAC_BITS/D) output strobes. Each output strobe is high in the cycle after the clock edge that samples the qualifying source strobe, so the first one follows the ceil(D/2^FRAC_BITS)-th source strobe.
- R6: A divisor of zero, which is the reset value, produces no output strobes.
- R7: A nonzero divisor of at most 2^FRAC_BITS passes every selected strobe, one output per source strobe.
- R8: An instance with INT_BITS and FRAC_BITS both zero forwards every selected strobe while enabled, with one cycle of latency.
- R9: Strobes on source slots other than the selected one have no effect on tick_o.
- R10: A write to the control word or to the divide word clears the accumulator. No output strobe comes from the cycle of the write.
- R11: After reset the control word reads 0 and tick_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | NUM_SRC | Per-source single-cycle strobes; slot 0 is ignored |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control write data: [3:0] source, [4] enable |
| div_wr_i | input | 1 | Divide word write strobe |
| div_wdata_i | input | 32 | Divide write data; divisor field around bit 12 |
| ctl_rdata_o | output | 8 | Control readback: [3:0] source, [4] enable, [7] busy |
| tick_o | output | 1 | Output clock-enable strobe |

## Verification
The bench counts output strobes over long runs at non-integer ratios. A divider that truncated the fraction, or mispositioned the field relative to bit 12, would give the integer-ratio count instead. It targets the divisor boundary cases: zero, which must stay silent rather than pass or lock up, and divisors at or below one, which must give exactly one output per input rather than wrap the accumulator. It also places writes between partial runs so that leftover accumulator phase would show up as an early strobe. Finally it drives every unselected slot, including a selected slot 0, with a full pulse pattern, where a muxing error would leak pulses.

// File: rtl/clkmux_pkg.sv
package clkmux_pkg;
  localparam int CTL_W        = 8;
  localparam int CTL_SRC_W    = 4;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_BUSY_BIT = 7;
  localparam int DIV_W        = 32;
  localparam int DIV_INT_LSB  = 12;
  localparam int MAX_SRC      = 1 << CTL_SRC_W;
endpackage

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel
  import clkmux_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0]   src_tick_i,
  input  logic [CTL_SRC_W-1:0] sel_i,
  output logic                 tick_o
);
  logic unused_slot0;
  assign unused_slot0 = src_tick_i[0];

  // slot 0 is a grounded source: the loop starts at 1
  always_comb begin
    tick_o = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (sel_i == CTL_SRC_W'(i)) tick_o = tick_o | src_tick_i[i];
    end
  end
endmodule

// File: rtl/clkdiv_frac_accum.sv
module clkdiv_frac_accum
  import clkmux_pkg::*;
#(
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             tick_i,
  output logic             tick_o
);
  localparam int DW = INT_BITS + FRAC_BITS;

  logic tick_d, tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end
  assign tick_o = tick_q;

  generate
    if (DW == 0) begin : g_pass
      logic unused_div;
      assign unused_div = ^{div_wr_i, div_wdata_i};
      always_comb tick_d = en_i & tick_i & ~restart_i;
    end else begin : g_frac
      localparam int AW  = DW + 1;
      localparam int LSB = DIV_INT_LSB - FRAC_BITS;
      localparam logic [AW-1:0]    STEP  = AW'(1) << FRAC_BITS;
      localparam logic [DIV_W-1:0] FIELD = ((DIV_W'(1) << DW) - DIV_W'(1)) << LSB;

      logic [DW-1:0] div_q;
      logic [AW-1:0] acc_q, acc_d, sum, dvs;
      logic          acc_ld;
      logic          unused_div;
      assign unused_div = ^(div_wdata_i & ~FIELD);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_q <= '0;
        else if (div_wr_i) div_q <= div_wdata_i[LSB +: DW];
      end

      always_comb begin
        dvs    = {1'b0, div_q};
        sum    = acc_q + STEP;
        acc_d  = acc_q;
        acc_ld = 1'b0;
        tick_d = 1'b0;
        if (restart_i) begin
          acc_d  = '0;
          acc_ld = 1'b1;
        end else if (en_i && tick_i && (div_q != '0)) begin
          acc_ld = 1'b1;
          if (dvs <= STEP) begin
            // ratio at or above one: every input passes, phase held at zero
            tick_d = 1'b1;
            acc_d  = '0;
          end else if (sum >= dvs) begin
            tick_d = 1'b1;
            acc_d  = sum - dvs;
          end else begin
            acc_d  = sum;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (acc_ld) acc_q <= acc_d;
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_mux.sv
module clkdiv_mux
  import clkmux_pkg::*;
#(
  parameter int NUM_SRC   = 16,  // at most MAX_SRC
  parameter int INT_BITS  = 12,  // DIV_INT_LSB + INT_BITS <= DIV_W
  parameter int FRAC_BITS = 12   // at most DIV_INT_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               ctl_wr_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  input  logic               div_wr_i,
  input  logic [DIV_W-1:0]   div_wdata_i,
  output logic [CTL_W-1:0]   ctl_rdata_o,
  output logic               tick_o
);
  logic [CTL_SRC_W-1:0] src_q, src_d;
  logic                 en_q, en_d;
  logic                 ctl_ld, restart, sel_tick;
  logic                 unused_ctl;

  assign unused_ctl = ^ctl_wdata_i[CTL_W-1:CTL_EN_BIT+1];

  always_comb begin
    ctl_ld = ctl_wr_i;
    src_d  = ctl_wdata_i[CTL_SRC_W-1:0];
    en_d   = ctl_wdata_i[CTL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      en_q  <= 1'b0;
    end else if (ctl_ld) begin
      src_q <= src_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    ctl_rdata_o               = '0;
    ctl_rdata_o[CTL_SRC_W-1:0] = src_q;
    ctl_rdata_o[CTL_EN_BIT]   = en_q;
    ctl_rdata_o[CTL_BUSY_BIT] = en_q;
  end

  assign restart = ctl_wr_i | div_wr_i;

  clkdiv_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_tick_i (src_tick_i),
    .sel_i      (src_q),
    .tick_o     (sel_tick)
  );

  clkdiv_frac_accum #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_q),
    .restart_i   (restart),
    .div_wr_i    (div_wr_i),
    .div_wdata_i (div_wdata_i),
    .tick_i      (sel_tick),
    .tick_o      (tick_o)
  );
endmodule

// File: rtl/clkdiv_mux_chk.sv
module clkdiv_mux_chk
  import clkmux_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic               ctl_wr_i,
  input logic [CTL_W-1:0]   ctl_wdata_i,
  input logic               div_wr_i,
  input logic [DIV_W-1:0]   div_wdata_i,
  input logic [CTL_W-1:0]   ctl_rdata_o,
  input logic               tick_o
);
  localparam int DW = INT_BITS + FRAC_BITS;

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (ctl_rdata_o[CTL_SRC_W-1:0] == CTL_SRC_W'(i)) hit = hit | src_tick_i[i];
    end
  end

  // R2
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[CTL_EN_BIT] |=> !tick_o);

  // R3
  a_r3_busy_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> ctl_rdata_o[CTL_BUSY_BIT] == $past(ctl_wdata_i[CTL_EN_BIT]));

  // R9, and R1 since slot 0 never counts as a hit
  a_r9_unselected_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !tick_o);

  // R10
  a_r10_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i || div_wr_i) |=> !tick_o);

  generate
    if (DW == 0) begin : g_pass_chk
      logic unused_w;
      assign unused_w = ^div_wdata_i;
      // R8
      a_r8_pass_every: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata_o[CTL_EN_BIT] && hit && !ctl_wr_i && !div_wr_i) |=> tick_o);
    end else begin : g_div_chk
      localparam int LSB = DIV_INT_LSB - FRAC_BITS;
      logic zero_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        zero_q <= 1'b1;
        else if (div_wr_i) zero_q <= (div_wdata_i[LSB +: DW] == '0);
      end
      // R6
      a_r6_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |=> !tick_o);
    end
  endgenerate
endmodule

bind clkdiv_mux clkdiv_mux_chk #(
  .NUM_SRC   (NUM_SRC),
  .INT_BITS  (INT_BITS),
  .FRAC_BITS (FRAC_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_tick_i  (src_tick_i),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_wdata_i (ctl_wdata_i),
  .div_wr_i    (div_wr_i),
  .div_wdata_i (div_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .tick_o      (tick_o)
);

// File: tb/clkdiv_mux_bench.sv
`timescale 1ns/1ps
module clkdiv_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wd = '0;
  logic        div_wr = 1'b0;
  logic [31:0] div_wd = '0;
  logic [7:0]  ctl_rd;
  logic        tick;

  logic [3:0]  p_src = '0;
  logic        p_ctl_wr = 1'b0;
  logic [7:0]  p_ctl_wd = '0;
  logic [7:0]  p_ctl_rd;
  logic        p_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clkdiv_mux #(.NUM_SRC(8), .INT_BITS(8), .FRAC_BITS(4)) u_clkdiv_mux (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src), .ctl_wr_i(ctl_wr),
    .ctl_wdata_i(ctl_wd), .div_wr_i(div_wr), .div_wdata_i(div_wd),
    .ctl_rdata_o(ctl_rd), .tick_o(tick));

  clkdiv_mux #(.NUM_SRC(4), .INT_BITS(0), .FRAC_BITS(0)) u_pt (
    .clk(clk), .rst_n(rst_n), .src_tick_i(p_src), .ctl_wr_i(p_ctl_wr),
    .ctl_wdata_i(p_ctl_wd), .div_wr_i(1'b0), .div_wdata_i(32'h0),
    .ctl_rdata_o(p_ctl_rd), .tick_o(p_tick));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit en, input int s);
    ctl_wr = 1'b1;
    ctl_wd = {3'b000, en, 4'(s)};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_div(input int ip, input int fp, input logic [31:0] junk);
    div_wr = 1'b1;
    div_wd = junk | (32'(ip) << 12) | (32'(fp) << 8);
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic pump(input logic [7:0] pat, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      src = pat;
      @(negedge clk);
      cnt += int'(tick);
    end
    src = '0;
  endtask

  task automatic t_reset();
    int c;
    check(ctl_rd == 8'h00, "R11 ctl reset", int'(ctl_rd), 0);
    check(tick == 1'b0, "R11 tick reset", int'(tick), 0);
    pump(8'hFF, 20, c);
    check(c == 0, "R2 disabled after reset", c, 0);
  endtask

  task automatic t_readback();
    wr_ctl(1'b1, 1);
    check(ctl_rd == 8'h91, "R3 busy mirrors enable set", int'(ctl_rd), 'h91);
    ctl_wr = 1'b1; ctl_wd = 8'h85;
    @(negedge clk);
    ctl_wr = 1'b0;
    check(ctl_rd == 8'h05, "R3 busy write ignored", int'(ctl_rd), 'h05);
  endtask

  task automatic t_zero_div();
    int c;
    wr_ctl(1'b1, 1);
    pump(8'h02, 20, c);
    check(c == 0, "R6 reset divisor zero", c, 0);
    wr_div(0, 0, 32'hFFF0_00FF);
    pump(8'h02, 20, c);
    check(c == 0, "R6 zero field with junk bits", c, 0);
  endtask

  task automatic t_ratio();
    int c;
    wr_ctl(1'b1, 1);
    wr_div(2, 8, 32'h0);
    pump(8'h02, 2, c);
    check(c == 0, "R5 no strobe before third input", c, 0);
    pump(8'h02, 1, c);
    check(c == 1, "R5 strobe after third input", c, 1);
    wr_div(2, 8, 32'h0);
    pump(8'h02, 100, c);
    check(c == 40, "R5 ratio 2.5", c, 40);
    wr_div(3, 0, 32'h0);
    pump(8'h02, 100, c);
    check(c == 33, "R5 ratio 3", c, 33);
    wr_div(2, 8, 32'hFFF0_00FF);
    pump(8'h02, 100, c);
    check(c == 40, "R4 bits outside field ignored", c, 40);
  endtask

  task automatic t_small();
    int c;
    wr_ctl(1'b1, 2);
    wr_div(0, 8, 32'h0);
    pump(8'h04, 30, c);
    check(c == 30, "R7 divisor below one", c, 30);
    wr_div(1, 0, 32'h0);
    pump(8'h04, 30, c);
    check(c == 30, "R7 divisor exactly one", c, 30);
  endtask

  task automatic t_select();
    int c;
    wr_ctl(1'b1, 3);
    wr_div(1, 0, 32'h0);
    pump(8'hF7, 50, c);
    check(c == 0, "R9 unselected sources", c, 0);
    pump(8'h08, 10, c);
    check(c == 10, "R9 selected source runs", c, 10);
    wr_ctl(1'b1, 0);
    pump(8'hFF, 50, c);
    check(c == 0, "R1 slot 0 grounded", c, 0);
    wr_ctl(1'b0, 3);
    pump(8'hFF, 50, c);
    check(c == 0, "R2 enable cleared", c, 0);
  endtask

  task automatic t_restart();
    int c;
    wr_ctl(1'b1, 1);
    wr_div(2, 8, 32'h0);
    pump(8'h02, 2, c);
    wr_ctl(1'b1, 1);
    pump(8'h02, 2, c);
    check(c == 0, "R10 ctl write clears phase", c, 0);
    pump(8'h02, 1, c);
    check(c == 1, "R10 restart then third input", c, 1);
    pump(8'h02, 1, c);
    wr_div(2, 8, 32'h0);
    pump(8'h02, 2, c);
    check(c == 0, "R10 div write clears phase", c, 0);
  endtask

  task automatic t_pass();
    int c;
    p_ctl_wr = 1'b1; p_ctl_wd = 8'h12;
    @(negedge clk);
    p_ctl_wr = 1'b0;
    c = 0;
    for (int i = 0; i < 12; i++) begin
      p_src = (i % 3 == 0) ? 4'b0000 : 4'b0100;
      @(negedge clk);
      c += int'(p_tick);
    end
    p_src = '0;
    check(c == 8, "R8 pass-through count", c, 8);
    p_src = 4'b1011;
    @(negedge clk);
    p_src = 4'b0100;
    @(negedge clk);
    check(p_tick == 1'b1, "R8 one cycle latency", int'(p_tick), 1);
    p_src = '0;
    @(negedge clk);
    check(p_tick == 1'b0, "R8 strobe lasts one cycle", int'(p_tick), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_zero_div();
    t_ratio();
    t_small();
    t_select();
    t_restart();
    t_pass();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule